// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is the serial core of a byte-wide SPI master. Software writes one 32-bit control word that fixes the clock polarity, the sampling phase, the bit order, the receive-discard option and the chip-select behaviour. Setting the start bit in that word launches a burst. The engine clocks a programmed total number of bytes. Only the first bytes, up to a separate transmit count, are taken from an external transmit FIFO. The bytes after them go out as zero-valued filler. Each received byte is pushed into an external receive FIFO unless discard mode is on.

The serial clock rate comes from an outside divider. It supplies a single-cycle enable pulse, and each pulse moves SCK by one half period. When the burst ends, the start bit drops by itself and a sticky transfer-complete flag rises. The flag stays set until it is cleared. Both counts are sampled when the burst is accepted.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the control word reads 0, the completion flag is 0, SCK is low, and all four chip selects sit at their inactive level (high, since the polarity bit is 0).
- R2: Writing a control word with bit 31 set, while the engine is idle and the bus is enabled, starts a burst. Bit 31 reads 1 until the burst ends and then returns to 0. The completion flag is set at that moment and is cleared by a pulse on `tc_clr`.
- R3: A start request while `bus_en` is low does not start a burst. While a burst runs, control writes of any kind are ignored, and the burst continues with its original settings.
- R4: A burst clocks exactly `burst_len` bytes of 8 SCK cycles each. A burst length of 0 completes with no SCK edge.
- R5: The first min(`xmit_len`, `burst_len`) bytes are popped from the TX FIFO, one pop per byte. Every later byte is sent as 0x00 without a pop.
- R6: When bit 8 (discard) is set, nothing is pushed to the RX FIFO. Otherwise each byte produces one push that carries the byte received on MISO.
- R7: Bit 1 (CPOL) sets the SCK idle level while the bus is enabled. Bit 0 (CPHA) selects sampling on the leading edge (0) or the trailing edge (1). In both cases MOSI changes on the opposite edge.
- R8: Bit 12 selects LSB-first (1) or MSB-first (0) bit order, and the same order applies to MOSI and MISO.
- R9: In automatic mode (bit 6 = 0), the output picked by bits 5:4 takes the active level from bit 2 (0 = active low) while a burst runs. All other outputs stay at the inactive level.
- R10: In manual mode (bit 6 = 1), the picked output copies bit 7 directly, whether or not a burst runs. The others stay inactive.
- R11: If a transmit byte is still owed and the TX FIFO is empty, SCK stays at its idle level and no pop occurs until data is available.
- R12: While `bus_en` is low, SCK is driven low whatever CPOL is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus enable; gates SCK and start requests |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_q | output | 32 | Current control word (bit 31 = burst running) |
| burst_len | input | 24 | Total bytes per burst, sampled at start |
| xmit_len | input | 24 | Bytes taken from the TX FIFO, sampled at start |
| tc_clr | input | 1 | Clears the completion flag |
| tc_flag | output | 1 | Sticky transfer-complete flag |
| sclk_tick | input | 1 | Half-period enable pulse from the divider |
| tx_data | input | 8 | TX FIFO head byte |
| tx_empty | input | 1 | TX FIFO empty |
| tx_pop | output | 1 | TX FIFO pop |
| rx_data | output | 8 | Byte for the RX FIFO |
| rx_push | output | 1 | RX FIFO push |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 4 | Chip-select outputs |

## Verification
The properties assume a few things about the inputs:
- The TX FIFO head is valid whenever `tx_empty` is low.
- The RX FIFO can always accept a push.
- `sclk_tick` is a clean single-cycle pulse.
- `bus_en` does not drop in the middle of a burst.

The stimulus keeps within these assumptions. Its FIFO model exposes a byte only after it has been written. It accepts every push. It produces the tick from a free-running toggle. It changes `bus_en` only while the engine is idle. The serial slave in the stimulus samples MOSI and updates MISO only on the mode's own edges, so the phase and bit-order checks compare against an independently decoded byte stream.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
   // Control word field positions (neighbouring software decodes these)
   localparam int CF_CPHA    = 0;
   localparam int CF_CPOL    = 1;
   localparam int CF_CSPOL   = 2;
   localparam int CF_CSIDX   = 4;
   localparam int CF_MANUAL  = 6;
   localparam int CF_CSLEVEL = 7;
   localparam int CF_DISCARD = 8;
   localparam int CF_LSBF    = 12;
   localparam int CF_START   = 31;
   localparam int CF_CSIDX_W = 2;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_FETCH = 2'd1,
      ENG_SHIFT = 2'd2
   } eng_state_e;
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
   import spi_burst_pkg::*;
#(
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              burst_done,
   input  logic              tc_clr,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              go,
   output logic              tc_flag
);
   logic running;

   assign running = ctrl_q[CF_START];
   assign go      = wr & ~running & bus_en & wdata[CF_START];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr && !running) begin
         ctrl_q <= {go, wdata[CTRL_W-2:0]};
      end else if (burst_done) begin
         ctrl_q[CF_START] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_flag <= 1'b0;
      end else if (burst_done) begin
         tc_flag <= 1'b1;
      end else if (tc_clr) begin
         tc_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
   parameter int NUM_CS = 4,
   parameter int IDX_W  = 2
) (
   input  logic              manual,
   input  logic              level,
   input  logic              polarity,
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic              active,
   output logic [NUM_CS-1:0] cs_out
);
   logic sel_level;

   assign sel_level = manual ? level : (active ? polarity : ~polarity);

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
      assign cs_out[gi] = (sel_idx == IDX_W'(gi)) ? sel_level : ~polarity;
   end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
   import spi_burst_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CNT_W-1:0]  burst_len,
   input  logic [CNT_W-1:0]  xmit_len,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic              discard,
   input  logic              sclk_tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_empty,
   output logic              tx_pop,
   input  logic              miso,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic              sck_act,
   output logic              mosi,
   output logic              done
);
   localparam int IDX_W  = $clog2(DATA_W);
   localparam int EDGE_W = IDX_W + 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   eng_state_e        state_q;
   logic [CNT_W-1:0]  burst_left_q, tx_left_q;
   logic [DATA_W-1:0] byte_q, rx_q, rx_nxt, rx_out_q, fetch_byte;
   logic [EDGE_W-1:0] edge_q;
   logic [IDX_W-1:0]  bit_idx, rx_pos;
   logic              lead, sample_now, last_edge, fetch_ok, owe_tx;
   logic              push_q, done_q, sck_q, mosi_q;

   function automatic logic bit_of(input logic [DATA_W-1:0] b,
                                   input logic [IDX_W-1:0] i,
                                   input logic lsb);
      return lsb ? b[i] : b[LAST_IDX - i];
   endfunction

   assign bit_idx    = edge_q[EDGE_W-1:1];
   assign lead       = ~edge_q[0];
   assign rx_pos     = lsb_first ? bit_idx : (LAST_IDX - bit_idx);
   assign last_edge  = (edge_q == {EDGE_W{1'b1}});
   assign sample_now = (state_q == ENG_SHIFT) & sclk_tick & (lead ^ cpha);
   assign owe_tx     = (tx_left_q != '0);
   assign fetch_ok   = (state_q == ENG_FETCH) & (~owe_tx | ~tx_empty);
   assign fetch_byte = owe_tx ? tx_data : '0;
   assign tx_pop     = (state_q == ENG_FETCH) & owe_tx & ~tx_empty;

   always_comb begin
      rx_nxt = rx_q;
      if (sample_now) rx_nxt[rx_pos] = miso;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ENG_IDLE;
         burst_left_q <= '0;
         tx_left_q    <= '0;
         byte_q       <= '0;
         rx_q         <= '0;
         rx_out_q     <= '0;
         edge_q       <= '0;
         push_q       <= 1'b0;
         done_q       <= 1'b0;
         sck_q        <= 1'b0;
         mosi_q       <= 1'b0;
      end else begin
         push_q <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ENG_IDLE: begin
               if (go) begin
                  burst_left_q <= burst_len;
                  tx_left_q    <= (xmit_len > burst_len) ? burst_len : xmit_len;
                  sck_q        <= 1'b0;
                  if (burst_len == '0) done_q  <= 1'b1;
                  else                 state_q <= ENG_FETCH;
               end
            end
            ENG_FETCH: begin
               if (fetch_ok) begin
                  byte_q <= fetch_byte;
                  if (owe_tx) tx_left_q <= tx_left_q - 1'b1;
                  edge_q <= '0;
                  rx_q   <= '0;
                  if (!cpha) mosi_q <= bit_of(fetch_byte, '0, lsb_first);
                  state_q <= ENG_SHIFT;
               end
            end
            ENG_SHIFT: begin
               if (sclk_tick) begin
                  sck_q  <= ~sck_q;
                  edge_q <= edge_q + 1'b1;
                  rx_q   <= rx_nxt;
                  if (lead && cpha)
                     mosi_q <= bit_of(byte_q, bit_idx, lsb_first);
                  if (!lead && !cpha && bit_idx != LAST_IDX)
                     mosi_q <= bit_of(byte_q, bit_idx + 1'b1, lsb_first);
                  if (last_edge) begin
                     rx_out_q     <= rx_nxt;
                     push_q       <= ~discard;
                     burst_left_q <= burst_left_q - 1'b1;
                     if (burst_left_q == CNT_W'(1)) begin
                        state_q <= ENG_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= ENG_FETCH;
                     end
                  end
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign rx_data = rx_out_q;
   assign rx_push = push_q;
   assign sck_act = sck_q;
   assign mosi    = mosi_q;
   assign done    = done_q;
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
   import spi_burst_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 24,
   parameter int NUM_CS = 4,
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   input  logic [CNT_W-1:0]  burst_len,
   input  logic [CNT_W-1:0]  xmit_len,
   input  logic              tc_clr,
   output logic              tc_flag,
   input  logic              sclk_tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_empty,
   output logic              tx_pop,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_out
);
   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 2");
   end
   if (NUM_CS < 1 || NUM_CS > (1 << CF_CSIDX_W)) begin : g_bad_num_cs
      $error("NUM_CS must fit the chip-select index field");
   end
   if (CTRL_W != 32) begin : g_bad_ctrl_w
      $error("CTRL_W must be 32 to hold the start bit at its position");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("CNT_W must be at least 1");
   end

   logic go, burst_done, sck_act;

   spi_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .wr         (ctrl_wr),
      .wdata      (ctrl_wdata),
      .burst_done (burst_done),
      .tc_clr     (tc_clr),
      .ctrl_q     (ctrl_q),
      .go         (go),
      .tc_flag    (tc_flag)
   );

   spi_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .burst_len  (burst_len),
      .xmit_len   (xmit_len),
      .cpha       (ctrl_q[CF_CPHA]),
      .lsb_first  (ctrl_q[CF_LSBF]),
      .discard    (ctrl_q[CF_DISCARD]),
      .sclk_tick  (sclk_tick),
      .tx_data    (tx_data),
      .tx_empty   (tx_empty),
      .tx_pop     (tx_pop),
      .miso       (miso),
      .rx_data    (rx_data),
      .rx_push    (rx_push),
      .sck_act    (sck_act),
      .mosi       (mosi),
      .done       (burst_done)
   );

   spi_cs_drive #(.NUM_CS(NUM_CS), .IDX_W(CF_CSIDX_W)) u_cs (
      .manual   (ctrl_q[CF_MANUAL]),
      .level    (ctrl_q[CF_CSLEVEL]),
      .polarity (ctrl_q[CF_CSPOL]),
      .sel_idx  (ctrl_q[CF_CSIDX +: CF_CSIDX_W]),
      .active   (ctrl_q[CF_START]),
      .cs_out   (cs_out)
   );

   assign sck = bus_en ? (ctrl_q[CF_CPOL] ^ sck_act) : 1'b0;
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic [31:0]       ctrl_q,
   input logic              tc_flag,
   input logic              tx_pop,
   input logic              tx_empty,
   input logic              rx_push,
   input logic              sck,
   input logic [NUM_CS-1:0] cs_out
);
   AST_CS_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cs_out ^ {NUM_CS{~ctrl_q[2]}}) <= 1); // R9
   AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty); // R11
   AST_POP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> ctrl_q[31]); // R5
   AST_DISCARD_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !ctrl_q[8]); // R6
   AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !ctrl_q[31]) |-> (sck == ctrl_q[1])); // R7
   AST_SCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> !sck); // R12
   AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q[31]) |-> tc_flag); // R2
endmodule

bind spi_burst_master spi_burst_master_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_en   (bus_en),
   .ctrl_q   (ctrl_q),
   .tc_flag  (tc_flag),
   .tx_pop   (tx_pop),
   .tx_empty (tx_empty),
   .rx_push  (rx_push),
   .sck      (sck),
   .cs_out   (cs_out)
);

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb_top;
   typedef struct packed {
      logic       cpol, cpha, lsb, disc;
      logic [1:0] cs;
      logic [7:0] burst, xmit, txs, rxs;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3, 8'd3, 8'hA5, 8'h3C},
      '{1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'd4, 8'd2, 8'h5A, 8'hC1},
      '{1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 8'd2, 8'd2, 8'h81, 8'h7E},
      '{1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 8'd3, 8'd1, 8'hF0, 8'h0F},
      '{1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 8'd5, 8'd5, 8'h12, 8'h34},
      '{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'd2, 8'd6, 8'h96, 8'h69}
   };

   logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b0, ctrl_wr = 1'b0, tc_clr = 1'b0;
   logic [31:0] ctrl_wdata = '0, ctrl_q;
   logic [23:0] burst_len = '0, xmit_len = '0;
   logic tc_flag, tick = 1'b0, tx_pop, rx_push, sck, mosi, miso;
   logic [7:0] tx_data, rx_data;
   logic [3:0] cs_out;

   logic [7:0] fifo_mem [32];
   int fifo_rd = 0, fifo_wr = 0;
   logic fifo_rst = 1'b0, rx_clr = 1'b0;
   logic [7:0] rx_mem [32];
   int rx_n = 0;

   logic slave_on = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
   logic [3:0] exp_cs = 4'hF;
   logic [7:0] rx_seed = '0;
   logic [7:0] mosi_cap [32];
   int slave_bits = 0, cs_bad = 0;
   int n_checks = 0, n_errors = 0;

   always #10 clk = ~clk;

   spi_burst_master dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .ctrl_wr(ctrl_wr),
      .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .burst_len(burst_len),
      .xmit_len(xmit_len), .tc_clr(tc_clr), .tc_flag(tc_flag),
      .sclk_tick(tick), .tx_data(tx_data), .tx_empty(tx_empty_w),
      .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push), .sck(sck),
      .mosi(mosi), .miso(miso), .cs_out(cs_out)
   );
   logic tx_empty_w;

   assign tx_empty_w = (fifo_rd >= fifo_wr);
   assign tx_data    = fifo_mem[fifo_rd % 32];

   always @(posedge clk) begin
      tick <= ~tick;
      if (fifo_rst) fifo_rd <= 0;
      else if (tx_pop) fifo_rd <= fifo_rd + 1;
      if (rx_clr) rx_n <= 0;
      else if (rx_push) begin
         rx_mem[rx_n % 32] <= rx_data;
         rx_n <= rx_n + 1;
      end
   end

   always_comb begin
      logic [7:0] cur;
      int p;
      cur  = rx_seed + 8'((slave_bits / 8));
      p    = slave_bits % 8;
      miso = cfg_lsb ? cur[p] : cur[7 - p];
   end

   always @(sck) begin
      if (slave_on && ((sck != cfg_cpol) ^ cfg_cpha)) begin
         mosi_cap[(slave_bits / 8) % 32][cfg_lsb ? (slave_bits % 8) : (7 - slave_bits % 8)] = mosi;
         if (cs_out !== exp_cs) cs_bad = cs_bad + 1;
         slave_bits = slave_bits + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [31:0] w);
      @(negedge clk);
      ctrl_wr = 1'b1;
      ctrl_wdata = w;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (!ctrl_q[31]) break;
      end
   endtask

   task automatic clear_bench();
      @(negedge clk);
      fifo_rst = 1'b1; rx_clr = 1'b1; tc_clr = 1'b1;
      fifo_wr = 0;
      slave_bits = 0; cs_bad = 0;
      for (int i = 0; i < 32; i++) mosi_cap[i] = '0;
      @(negedge clk);
      fifo_rst = 1'b0; rx_clr = 1'b0; tc_clr = 1'b0;
   endtask

   function automatic logic [31:0] cfg_word(input vec_t v, input logic pol);
      return {19'd0, v.lsb, 3'd0, v.disc, 1'b0, 1'b0, v.cs, 1'b0, pol, v.cpol, v.cpha};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ctrl", ctrl_q, 32'h0);
      check("R1 tc_flag", {31'd0, tc_flag}, 32'h0);
      check("R1 sck", {31'd0, sck}, 32'h0);
      check("R1 cs", {28'd0, cs_out}, 32'hF);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ctrl after release", ctrl_q, 32'h0);

      // R3 / R12: start with bus disabled
      clear_bench();
      burst_len = 24'd2; xmit_len = 24'd0;
      wr_ctrl(32'h8000_0002);
      repeat (4) @(negedge clk);
      check("R3 start ignored when bus off", {31'd0, ctrl_q[31]}, 32'h0);
      check("R12 sck low when bus off", {31'd0, sck}, 32'h0);
      check("R3 no completion", {31'd0, tc_flag}, 32'h0);
      bus_en = 1'b1;
      @(negedge clk);
      check("R7 idle level follows CPOL", {31'd0, sck}, 32'h1);

      // Vector table: R4 R5 R6 R7 R8 R9
      for (int vi = 0; vi < NVEC; vi++) begin
         automatic vec_t v = VECS[vi];
         automatic logic pol = 1'(vi % 2);
         automatic int npop = (v.xmit > v.burst) ? int'(v.burst) : int'(v.xmit);
         automatic int bad;
         clear_bench();
         for (int k = 0; k < 32; k++) fifo_mem[k] = v.txs + 8'(k);
         fifo_wr = int'(v.xmit) + 2;
         burst_len = 24'(v.burst); xmit_len = 24'(v.xmit);
         wr_ctrl(cfg_word(v, pol));
         cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_lsb = v.lsb; rx_seed = v.rxs;
         exp_cs = pol ? 4'h0 : 4'hF;
         exp_cs[v.cs] = pol;
         @(negedge clk);
         slave_on = 1'b1;
         wr_ctrl(cfg_word(v, pol) | 32'h8000_0000);
         wait_idle();
         slave_on = 1'b0;
         repeat (2) @(negedge clk);
         check($sformatf("R4 bits clocked vec%0d", vi), slave_bits, int'(v.burst) * 8);
         bad = 0;
         for (int k = 0; k < int'(v.burst); k++)
            if (mosi_cap[k] !== ((k < int'(v.xmit)) ? v.txs + 8'(k) : 8'h00)) bad++;
         check($sformatf("R5 R8 mosi bytes vec%0d", vi), bad, 0);
         check($sformatf("R5 pops vec%0d", vi), fifo_rd, npop);
         check($sformatf("R6 push count vec%0d", vi), rx_n, v.disc ? 0 : int'(v.burst));
         bad = 0;
         if (!v.disc)
            for (int k = 0; k < int'(v.burst); k++)
               if (rx_mem[k] !== v.rxs + 8'(k)) bad++;
         check($sformatf("R6 R7 R8 rx bytes vec%0d", vi), bad, 0);
         check($sformatf("R9 cs during burst vec%0d", vi), cs_bad, 0);
         check($sformatf("R2 flag vec%0d", vi), {31'd0, tc_flag}, 32'h1);
         check($sformatf("R7 sck idle vec%0d", vi), {31'd0, sck}, {31'd0, v.cpol});
         check($sformatf("R9 cs idle vec%0d", vi), {28'd0, cs_out}, pol ? 32'h0 : 32'hF);
      end

      // R2: clear completion flag
      @(negedge clk); tc_clr = 1'b1; @(negedge clk); tc_clr = 1'b0;
      check("R2 tc_clr clears flag", {31'd0, tc_flag}, 32'h0);

      // R4: zero-length burst
      clear_bench();
      burst_len = 24'd0; xmit_len = 24'd0;
      cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb = 1'b0; slave_on = 1'b1;
      wr_ctrl(32'h8000_0000);
      repeat (3) @(negedge clk);
      slave_on = 1'b0;
      check("R4 zero burst done", {31'd0, ctrl_q[31]}, 32'h0);
      check("R4 zero burst flag", {31'd0, tc_flag}, 32'h1);
      check("R4 zero burst no edges", slave_bits, 0);

      // R11: stall on empty TX FIFO, then R3: writes during burst ignored
      clear_bench();
      burst_len = 24'd1; xmit_len = 24'd1;
      exp_cs = 4'hE;
      slave_on = 1'b1;
      wr_ctrl(32'h8000_0000);
      repeat (30) @(negedge clk);
      check("R11 sck held idle", {31'd0, sck}, 32'h0);
      check("R11 still running", {31'd0, ctrl_q[31]}, 32'h1);
      check("R11 no edges while empty", slave_bits, 0);
      wr_ctrl(32'h8000_1037);
      check("R3 write during burst ignored", ctrl_q, 32'h8000_0000);
      fifo_mem[0] = 8'hC3;
      fifo_wr = 1;
      wait_idle();
      slave_on = 1'b0;
      repeat (2) @(negedge clk);
      check("R11 byte sent after data arrives", {24'd0, mosi_cap[0]}, 32'hC3);
      check("R3 original settings kept", slave_bits, 8);

      // R10: manual chip select
      wr_ctrl(32'h0000_0060);
      check("R10 manual level 0 idx2", {28'd0, cs_out}, 32'hB);
      wr_ctrl(32'h0000_00D4);
      check("R10 manual level 1 idx1 pol1", {28'd0, cs_out}, 32'h2);
      clear_bench();
      burst_len = 24'd2; xmit_len = 24'd0;
      exp_cs = 4'h7;
      slave_on = 1'b1;
      wr_ctrl(32'h8000_0070);
      wait_idle();
      slave_on = 1'b0;
      check("R10 manual level held during burst", cs_bad, 0);
      check("R10 manual burst clocked", slave_bits, 16);
      check("R10 manual level after burst", {28'd0, cs_out}, 32'h7);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule